// File: doc/BRIEF.md
# Indirect XOR Execute Sequencer

This block carries out a register-indirect exclusive-OR for a 16-bit processor. A start pulse hands it a 10-bit decoded opcode made of a 4-bit major field, a 3-bit address-register field (`aaa`) and a 3-bit destination field (`ddd`). The block reads the address register from an external eight-entry register file. It fetches the operand through a request/valid memory read port. It then writes the old destination value XORed with the operand back to the destination, and updates its sign and zero flags. Address registers R4 and R5 step forward after every read. R6 behaves as a stack pointer and steps back before every read. R1 to R3 stay unchanged. When pair mode is active, two reads are made and the operand is assembled from the low byte of each.

The controller is a state machine with eight states:

- IDLE: waits for start.
- PREP: loads the address pointer.
- RD1 and RD2: issue the first and second memory requests.
- WT1 and WT2: wait for the matching read data.
- PAD: burns cycles up to the fixed instruction length.
- FIN: performs the writeback and raises done.

The transitions are:

- IDLE goes to PREP on a legal start. An illegal start stays in IDLE and pulses `illegal`.
- PREP goes to RD1.
- RD1 goes to WT1.
- WT1 holds while data is not valid. On valid it goes to RD2 in pair mode, otherwise to PAD.
- RD2 goes to WT2.
- WT2 holds while data is not valid. On valid it goes to PAD.
- PAD goes to FIN once the cycle counter reaches one less than the target length.
- FIN goes back to IDLE.

Top module: `ixs_xor_seq`

## Requirements
- R1: A start is legal only when opcode[9:6] is 4'b1111 and `aaa` (opcode[5:3]) is neither 0 nor 7. An illegal start causes the following:
  - `illegal` is high for exactly one cycle, in the cycle after start.
  - There are no register writes and no memory requests.
  - The flags are left unchanged.
  - `busy` stays low.
- R2: On completion, register `ddd` (opcode[2:0]) receives its previous value XOR the operand.
- R3: `flag_sign` takes result bit 15 and `flag_zero` is set when the result is zero. Both change only in the cycle after done, and both reset to 0.
- R4: With pair mode low, the operand is the full 16-bit word read from memory.
- R5: With pair mode high, the operand has two parts:
  - Bits 7:0 are the low byte of the first read.
  - Bits 15:8 are the low byte of the second read.
- R6: R1, R2 and R3 are never written when used as the address register. In pair mode, both reads use the same address.
- R7: With R4 or R5 as the address register, each read uses the current value and is followed by an increment of one. A pair of reads therefore advances the register by two.
- R8: With R6 as the address register, each read is preceded by a decrement of one, and the read uses the decremented value.
- R9: With pair mode low and no wait cycles, the instruction takes 8 cycles for R1 to R5 and 11 cycles for R6. The start cycle counts as cycle 1 and the done cycle is the last.
- R10: With pair mode high and no wait cycles, the instruction takes 10 cycles for every address register.
- R11: Each cycle in which a read response is late extends the instruction by exactly one cycle.
- R12: The following hold for `busy` and `done`:
  - `busy` is high from the cycle after start through the done cycle.
  - `done` lasts exactly one cycle and coincides with the destination write.
  - Outputs are idle after reset.
- R13: When `ddd` equals `aaa`, the XOR uses the address register value after its pointer updates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle start pulse, accepted in IDLE |
| opcode | input | 10 | Major field, address-register field, destination field |
| pair_mode | input | 1 | Two-read low-byte operand mode |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final cycle, with writeback |
| illegal | output | 1 | Start rejected |
| rf_a_sel | output | 3 | Register file read select, address register |
| rf_a_data | input | 16 | Register file read data, address register |
| rf_d_sel | output | 3 | Register file read select, destination |
| rf_d_data | input | 16 | Register file read data, destination |
| rf_we | output | 1 | Register file write enable |
| rf_wsel | output | 3 | Register file write select |
| rf_wdata | output | 16 | Register file write data |
| mem_req | output | 1 | Memory read request, one cycle |
| mem_addr | output | 16 | Memory read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| flag_sign | output | 1 | Sign flag |
| flag_zero | output | 1 | Zero flag |

## Verification
The assertions assume the following about the environment:
- Start is raised only while the block is idle.
- `mem_valid` arrives only in answer to an outstanding request.
- At most one request is outstanding at a time.

The bench satisfies these in three ways. It waits for done or `illegal` before each new start. Its memory model answers each request exactly once, either in the following cycle or after a programmed delay. Its register file is combinational, so the value read in the pointer-load state is the current one.

// File: rtl/ixs_pkg.sv
package ixs_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PREP,
        S_RD1,
        S_WT1,
        S_RD2,
        S_WT2,
        S_PAD,
        S_FIN
    } ixs_state_t;
endpackage

// File: rtl/ixs_addr_step.sv
module ixs_addr_step #(
    parameter int DW     = 16,
    parameter int RSW    = 3,
    parameter int NREGS  = 8,
    parameter int INC_LO = 4
) (
    input  logic [RSW-1:0] sel,
    input  logic [DW-1:0]  cur,
    output logic [DW-1:0]  rd_addr,
    output logic [DW-1:0]  inc_val,
    output logic           pre_wr,
    output logic           post_wr
);
    localparam logic [RSW-1:0] STACK_SEL = RSW'(NREGS - 2);
    localparam logic [RSW-1:0] INC_FIRST = RSW'(INC_LO);

    logic is_stack;
    logic is_inc;

    assign is_stack = (sel == STACK_SEL);
    assign is_inc   = (sel >= INC_FIRST) && (sel < STACK_SEL);
    // stack register reads below its current top; stepping registers read at the pointer
    assign rd_addr  = is_stack ? (cur - DW'(1)) : cur;
    assign inc_val  = cur + DW'(1);
    assign pre_wr   = is_stack;
    assign post_wr  = is_inc;
endmodule

// File: rtl/ixs_xor_alu.sv
module ixs_xor_alu #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] dst_old,
    input  logic [DW-1:0] w_first,
    input  logic [DW-1:0] w_second,
    input  logic          pair,
    output logic [DW-1:0] result,
    output logic          neg,
    output logic          zero
);
    localparam int HB = DW / 2;

    logic [DW-1:0] operand;

    assign operand = pair ? {w_second[HB-1:0], w_first[HB-1:0]} : w_first;
    assign result  = dst_old ^ operand;
    assign neg     = result[DW-1];
    assign zero    = (result == '0);
endmodule

// File: rtl/ixs_xor_seq.sv
module ixs_xor_seq
    import ixs_pkg::*;
#(
    parameter int DW        = 16,
    parameter int NREGS     = 8,
    parameter int INC_LO    = 4,
    parameter int CYC_PLAIN = 8,
    parameter int CYC_STACK = 11,
    parameter int CYC_PAIR  = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [4+2*$clog2(NREGS)-1:0] opcode,
    input  logic                     pair_mode,
    output logic                     busy,
    output logic                     done,
    output logic                     illegal,
    output logic [$clog2(NREGS)-1:0] rf_a_sel,
    input  logic [DW-1:0]            rf_a_data,
    output logic [$clog2(NREGS)-1:0] rf_d_sel,
    input  logic [DW-1:0]            rf_d_data,
    output logic                     rf_we,
    output logic [$clog2(NREGS)-1:0] rf_wsel,
    output logic [DW-1:0]            rf_wdata,
    output logic                     mem_req,
    output logic [DW-1:0]            mem_addr,
    input  logic                     mem_valid,
    input  logic [DW-1:0]            mem_rdata,
    output logic                     flag_sign,
    output logic                     flag_zero
);
    localparam int RSW     = $clog2(NREGS);
    localparam int OPW     = 4 + 2 * RSW;
    localparam int CYC_A   = (CYC_PLAIN > CYC_PAIR) ? CYC_PLAIN : CYC_PAIR;
    localparam int CYC_MAX = (CYC_STACK > CYC_A) ? CYC_STACK : CYC_A;
    localparam int CNTW    = $clog2(CYC_MAX + 2);
    localparam logic [RSW-1:0] STACK_SEL = RSW'(NREGS - 2);
    localparam logic [RSW-1:0] IMM_SEL   = RSW'(NREGS - 1);

    ixs_state_t state_q, state_d;

    logic [RSW-1:0]  aaa_in, ddd_in, aaa_q, ddd_q;
    logic            legal, pair_q, stall, illegal_q;
    logic [CNTW-1:0] cnt_q, tgt_len;
    logic [DW-1:0]   ptr_q, w0_q, w1_q;
    logic [DW-1:0]   step_rd, step_inc, alu_res;
    logic            step_pre, step_post, alu_neg, alu_zero;
    logic            sign_q, zero_q;

    assign aaa_in = opcode[2*RSW-1:RSW];
    assign ddd_in = opcode[RSW-1:0];
    assign legal  = (opcode[OPW-1:2*RSW] == 4'b1111)
                 && (aaa_in != '0) && (aaa_in != IMM_SEL);

    assign tgt_len = pair_q ? CNTW'(CYC_PAIR)
                   : ((aaa_q == STACK_SEL) ? CNTW'(CYC_STACK) : CNTW'(CYC_PLAIN));
    assign stall   = ((state_q == S_WT1) || (state_q == S_WT2)) && !mem_valid;

    ixs_addr_step #(.DW(DW), .RSW(RSW), .NREGS(NREGS), .INC_LO(INC_LO)) u_step (
        .sel     (aaa_q),
        .cur     (ptr_q),
        .rd_addr (step_rd),
        .inc_val (step_inc),
        .pre_wr  (step_pre),
        .post_wr (step_post)
    );

    ixs_xor_alu #(.DW(DW)) u_alu (
        .dst_old  (rf_d_data),
        .w_first  (w0_q),
        .w_second (w1_q),
        .pair     (pair_q),
        .result   (alu_res),
        .neg      (alu_neg),
        .zero     (alu_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start && legal) state_d = S_PREP;
            S_PREP: state_d = S_RD1;
            S_RD1:  state_d = S_WT1;
            S_WT1:  if (mem_valid) state_d = pair_q ? S_RD2 : S_PAD;
            S_RD2:  state_d = S_WT2;
            S_WT2:  if (mem_valid) state_d = S_PAD;
            S_PAD:  if (cnt_q == tgt_len - CNTW'(1)) state_d = S_FIN;
            S_FIN:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aaa_q     <= '0;
            ddd_q     <= '0;
            pair_q    <= 1'b0;
            cnt_q     <= '0;
            ptr_q     <= '0;
            w0_q      <= '0;
            w1_q      <= '0;
            sign_q    <= 1'b0;
            zero_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= (state_q == S_IDLE) && start && !legal;
            if (state_q == S_IDLE) begin
                if (start && legal) begin
                    aaa_q  <= aaa_in;
                    ddd_q  <= ddd_in;
                    pair_q <= pair_mode;
                    cnt_q  <= CNTW'(2);
                end
            end else if (!stall) begin
                cnt_q <= cnt_q + CNTW'(1);
            end
            if (state_q == S_PREP) ptr_q <= rf_a_data;
            if (((state_q == S_RD1) || (state_q == S_RD2)) && step_pre) ptr_q <= step_rd;
            if (state_q == S_WT1 && mem_valid) begin
                w0_q <= mem_rdata;
                if (step_post) ptr_q <= step_inc;
            end
            if (state_q == S_WT2 && mem_valid) begin
                w1_q <= mem_rdata;
                if (step_post) ptr_q <= step_inc;
            end
            if (state_q == S_FIN) begin
                sign_q <= alu_neg;
                zero_q <= alu_zero;
            end
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q != S_IDLE);
        done     = (state_q == S_FIN);
        illegal  = illegal_q;
        rf_a_sel = aaa_q;
        rf_d_sel = ddd_q;
        mem_req  = (state_q == S_RD1) || (state_q == S_RD2);
        mem_addr = step_rd;
        rf_we    = 1'b0;
        rf_wsel  = aaa_q;
        rf_wdata = step_inc;
        unique case (state_q)
            S_RD1, S_RD2: begin
                rf_we    = step_pre;
                rf_wdata = step_rd;
            end
            S_WT1, S_WT2: begin
                rf_we    = step_post && mem_valid;
            end
            S_FIN: begin
                rf_we    = 1'b1;
                rf_wsel  = ddd_q;
                rf_wdata = alu_res;
            end
            default: ;
        endcase
        flag_sign = sign_q;
        flag_zero = zero_q;
    end
endmodule

// File: rtl/ixs_checker.sv
module ixs_checker #(
    parameter int RSW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done,
    input logic           illegal,
    input logic           mem_req,
    input logic           rf_we,
    input logic [RSW-1:0] rf_wsel,
    input logic           flag_sign,
    input logic           flag_zero
);
    a_r12_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r12_done_writes: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rf_we);

    a_r1_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!busy && !rf_we && !mem_req));

    a_r1_illegal_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !illegal);

    // R6: only the stepping and stack registers are written outside the final cycle
    a_r6_ptr_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && !done) |-> (rf_wsel >= RSW'(4) && rf_wsel <= RSW'(6)));

    a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable({flag_sign, flag_zero}));

    a_r11_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r12_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, illegal, mem_req}));
endmodule

bind ixs_xor_seq ixs_checker #(.RSW($clog2(NREGS))) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal),
    .mem_req   (mem_req),
    .rf_we     (rf_we),
    .rf_wsel   (rf_wsel),
    .flag_sign (flag_sign),
    .flag_zero (flag_zero)
);

// File: tb/tb_ixs_xor_seq.sv
`timescale 1ns/1ps
module tb_ixs_xor_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [9:0]  opcode = '0;
    logic        pair_mode = 1'b0;
    logic        busy, done, illegal, rf_we, mem_req, flag_sign, flag_zero;
    logic [2:0]  rf_a_sel, rf_d_sel, rf_wsel;
    logic [15:0] rf_a_data, rf_d_data, rf_wdata, mem_addr;
    logic        mem_valid = 1'b0;
    logic [15:0] mem_rdata = '0;

    logic [15:0] rf   [8];
    logic [15:0] rf_m [8];
    int          wait_cfg = 0;
    int          pend_ctr = 0;
    logic        pend = 1'b0;
    logic [15:0] pend_addr = '0;
    int          errors = 0;
    int          checks = 0;
    logic        exp_sign = 1'b0;
    logic        exp_zero = 1'b0;

    always #2.5 clk = ~clk;

    ixs_xor_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .pair_mode(pair_mode),
        .busy(busy), .done(done), .illegal(illegal),
        .rf_a_sel(rf_a_sel), .rf_a_data(rf_a_data), .rf_d_sel(rf_d_sel), .rf_d_data(rf_d_data),
        .rf_we(rf_we), .rf_wsel(rf_wsel), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .flag_sign(flag_sign), .flag_zero(flag_zero)
    );

    assign rf_a_data = rf[rf_a_sel];
    assign rf_d_data = rf[rf_d_sel];

    function automatic logic [15:0] memf(input logic [15:0] a);
        return ((a ^ 16'h5a5a) * 16'd37) + 16'h0101;
    endfunction

    always @(posedge clk) if (rf_we) rf[rf_wsel] <= rf_wdata;

    // memory model: answers each request once, after wait_cfg late cycles
    always @(posedge clk) begin
        mem_valid <= 1'b0;
        if (mem_req) begin
            if (wait_cfg == 0) begin
                mem_valid <= 1'b1;
                mem_rdata <= memf(mem_addr);
            end else begin
                pend      <= 1'b1;
                pend_ctr  <= wait_cfg;
                pend_addr <= mem_addr;
            end
        end else if (pend) begin
            pend_ctr <= pend_ctr - 1;
            if (pend_ctr == 1) begin
                mem_valid <= 1'b1;
                mem_rdata <= memf(pend_addr);
                pend      <= 1'b0;
            end
        end
    end

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic init_rf(input int seed);
        for (int i = 0; i < 8; i++) begin
            rf[i]   = 16'h2000 + 16'(i) * 16'h0135 + 16'(seed) * 16'h0007;
            rf_m[i] = rf[i];
        end
    endtask

    // aaa, ddd, pair, wait, expected cycles
    localparam int NV = 12;
    localparam logic [13:0] VEC [NV] = '{
        {3'd1, 3'd0, 1'b0, 3'd0, 4'd8},
        {3'd2, 3'd3, 1'b1, 3'd0, 4'd10},
        {3'd3, 3'd5, 1'b0, 3'd0, 4'd8},
        {3'd4, 3'd1, 1'b0, 3'd0, 4'd8},
        {3'd5, 3'd2, 1'b1, 3'd0, 4'd10},
        {3'd6, 3'd0, 1'b0, 3'd0, 4'd11},
        {3'd6, 3'd7, 1'b1, 3'd0, 4'd10},
        {3'd4, 3'd4, 1'b0, 3'd0, 4'd8},
        {3'd5, 3'd5, 1'b1, 3'd0, 4'd10},
        {3'd6, 3'd6, 1'b0, 3'd0, 4'd11},
        {3'd4, 3'd3, 1'b0, 3'd2, 4'd10},
        {3'd6, 3'd1, 1'b1, 3'd1, 4'd12}
    };

    task automatic run_op(input logic [2:0] a, input logic [2:0] d, input logic pr,
                          input int wt, input int exp_cyc);
        logic [15:0] p, w0, w1, op, res;
        int cyc;
        string ptr_req;
        p = rf_m[a];
        w0 = '0;
        w1 = '0;
        for (int k = 0; k < (pr ? 2 : 1); k++) begin
            if (a == 3'd6) p = p - 16'd1;
            if (k == 0) w0 = memf(p); else w1 = memf(p);
            if (a == 3'd4 || a == 3'd5) p = p + 16'd1;
        end
        if (a >= 3'd4) rf_m[a] = p;
        op  = pr ? {w1[7:0], w0[7:0]} : w0;
        res = rf_m[d] ^ op;
        rf_m[d] = res;
        exp_sign = res[15];
        exp_zero = (res == 16'h0);

        wait_cfg = wt;
        @(negedge clk);
        opcode = {4'b1111, a, d};
        pair_mode = pr;
        start = 1'b1;
        cyc = 1;
        do begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end while (!done && cyc < 64);
        if (wt != 0)
            check(cyc == exp_cyc, "R11", "stalled cycle count", cyc, exp_cyc);
        else if (pr)
            check(cyc == exp_cyc, "R10", "pair cycle count", cyc, exp_cyc);
        else
            check(cyc == exp_cyc, "R9", "single cycle count", cyc, exp_cyc);
        @(negedge clk);
        check(!done && !busy, "R12", "done/busy after completion", {done, busy}, 0);
        if (a == d)
            check(rf[d] == rf_m[d], "R13", "dest equals address reg", rf[d], rf_m[d]);
        else
            check(rf[d] == rf_m[d], pr ? "R2/R5" : "R2/R4", "destination value", rf[d], rf_m[d]);
        if (a != d) begin
            if (a <= 3'd3)
                check(rf[a] == rf_m[a], "R6", "fixed address reg", rf[a], rf_m[a]);
            else if (a == 3'd6)
                check(rf[a] == rf_m[a], "R8", "stack reg predecrement", rf[a], rf_m[a]);
            else
                check(rf[a] == rf_m[a], "R7", "postincrement reg", rf[a], rf_m[a]);
        end
        check(flag_sign == exp_sign && flag_zero == exp_zero, "R3", "flags",
              {flag_sign, flag_zero}, {exp_sign, exp_zero});
    endtask

    task automatic run_bad(input logic [9:0] opc);
        logic [15:0] snap [8];
        for (int i = 0; i < 8; i++) snap[i] = rf[i];
        wait_cfg = 0;
        @(negedge clk);
        opcode = opc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(illegal && !busy && !mem_req, "R1", "illegal pulse", {illegal, busy, mem_req}, 3'b100);
        @(negedge clk);
        check(!illegal && !busy, "R1", "illegal one cycle, stays idle", {illegal, busy}, 0);
        for (int i = 0; i < 8; i++)
            check(rf[i] == snap[i], "R1", "register untouched", rf[i], snap[i]);
        check(flag_sign == exp_sign && flag_zero == exp_zero, "R1", "flags untouched",
              {flag_sign, flag_zero}, {exp_sign, exp_zero});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        init_rf(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !illegal && !mem_req && !rf_we, "R12", "reset idle outputs",
              {busy, done, illegal, mem_req, rf_we}, 0);
        check(!flag_sign && !flag_zero, "R3", "reset flags", {flag_sign, flag_zero}, 0);

        for (int v = 0; v < NV; v++) begin
            init_rf(v + 1);
            run_op(VEC[v][13:11], VEC[v][10:8], VEC[v][7], int'(VEC[v][6:4]), int'(VEC[v][3:0]));
        end

        // zero result: destination preloaded with the operand
        init_rf(20);
        rf[1] = 16'h0040; rf_m[1] = 16'h0040;
        rf[2] = memf(16'h0040); rf_m[2] = rf[2];
        run_op(3'd1, 3'd2, 1'b0, 0, 8);
        check(flag_zero && !flag_sign && rf[2] == 16'h0, "R3", "zero result flags",
              {flag_sign, flag_zero}, 2'b01);

        // negative result
        init_rf(21);
        rf[1] = 16'h0077; rf_m[1] = 16'h0077;
        rf[3] = memf(16'h0077) ^ 16'h8000; rf_m[3] = rf[3];
        run_op(3'd1, 3'd3, 1'b0, 0, 8);
        check(flag_sign && !flag_zero && rf[3] == 16'h8000, "R3", "negative result flags",
              {flag_sign, flag_zero}, 2'b10);

        // rejected encodings
        run_bad({4'b1111, 3'd0, 3'd2});
        run_bad({4'b1111, 3'd7, 3'd2});
        run_bad({4'b1011, 3'd4, 3'd2});

        // legal start after a rejection still works
        init_rf(22);
        run_op(3'd5, 3'd0, 1'b0, 0, 8);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule